// File: doc/BRIEF.md
# FIFO Fill-Level Flags with Programmable Thresholds

This block sits beside the storage array of a 2048-word dual-clock FIFO and turns the current word count into two registered status flags: a half-full indication and a combined near-boundary flag. The near-boundary flag is raised when the FIFO is close to empty (at or below a low threshold) or close to full (at or above the depth minus a high threshold). Both thresholds start at 256 and can be changed once per reset through the data-input port.

Threshold loading works with an active-low program strobe sampled on the write clock. The 10-bit value is made of the nine data bits plus the first write-enable pin, which supplies the most significant bit. The first strobed edge loads both thresholds. If the strobe is still low on the next edge, only the high threshold is loaded again. Loading is allowed only while the input-ready indication is high and before the first data word has been accepted. While a load is taking place, memory writes are held off no matter what the write enables show. The word count arrives already computed in the write-clock domain, from the write pointer and a synchronized read pointer, so the block runs on a single clock.

Top module: `fifo_level_flags`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) sets both thresholds to 256, half_full to 0 and near_edge to 1, and reopens the threshold-loading window.
- R2: One clock after the edge where fill_count is 1024 or more, half_full is 1; otherwise it is 0 at that point.
- R3: One clock after each edge, near_edge is 1 exactly when fill_count at that edge was less than or equal to lo_thresh, or greater than or equal to 2048 minus hi_thresh.
- R4: A load is accepted at an edge where prog_n is 0, in_ready is 1, the window is open, and the previous edge accepted no load. That load writes prog_val into both lo_thresh and hi_thresh. Bit 9 of prog_val is the MSB and comes from the first write-enable pin.
- R5: A load accepted on the edge right after another accepted load writes prog_val into hi_thresh only, and lo_thresh does not change.
- R6: A program strobe at an edge where in_ready is 0 changes neither threshold.
- R7: While a load is being accepted, wr_hold is 1 and wr_take is 0, even if both write enables are 1.
- R8: The first accepted data write closes the window. Every later strobe leaves both thresholds unchanged, does not raise wr_hold, and does not block writes, until the next reset.
- R9: wr_take is 1 exactly when wen_a, wen_b and in_ready are all 1 and wr_hold is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_n | input | 1 | Active-low threshold program strobe |
| prog_val | input | 10 | Threshold value; bit 9 is the first write-enable pin |
| wen_a | input | 1 | First write enable |
| wen_b | input | 1 | Second write enable |
| in_ready | input | 1 | FIFO not full |
| fill_count | input | 12 | Words held, 0 to 2048 |
| wr_take | output | 1 | Data write accepted this cycle |
| wr_hold | output | 1 | Memory write inhibit during threshold load |
| lo_thresh | output | 10 | Near-empty threshold |
| hi_thresh | output | 10 | Near-full threshold |
| half_full | output | 1 | Registered half-full flag |
| near_edge | output | 1 | Registered near-empty-or-near-full flag |

## Verification
Assertions check several properties on every cycle. The flags follow the count comparison one edge later. A second consecutive load leaves the low threshold unchanged. Once the window closes, it stays closed and the thresholds stay frozen. Loads never coincide with an accepted write, and no write is accepted without input-ready. Some behaviour only the bench scenarios can show: the exact values captured by the first and the repeated strobe, a strobe ignored because input-ready is low, a fresh pair load after a gap in the strobe, and the return to defaults after a second reset. For this the bench runs a behavioural model on every clock.

// File: rtl/lvl_pkg.sv
// Package: shared types for the FIFO level-flag block.
// Assumes: nothing beyond IEEE 1800-2017.
package lvl_pkg;

    // Phase of the threshold-loading window
    typedef enum logic [1:0] {
        WIN_OPEN   = 2'd0,  // window open, no load on previous edge
        WIN_LOADED = 2'd1,  // window open, load accepted on previous edge
        WIN_SHUT   = 2'd2   // first data write seen, loads refused
    } win_phase_t;

endpackage

// File: rtl/lvl_offset_prog.sv
// Module: threshold loader and write gate.
// Loads both thresholds on the first strobed edge and only the high one on a
// directly following strobed edge. Blocks memory writes during a load and
// closes the window on the first accepted data write.
// Assumes: prog_n, prog_val, enables and in_ready are synchronous to clk.
module lvl_offset_prog
    import lvl_pkg::*;
#(
    parameter int OFF_W   = 10,
    parameter int OFF_DEF = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic [OFF_W-1:0] prog_val,
    input  logic             wen_a,
    input  logic             wen_b,
    input  logic             in_ready,
    output logic [OFF_W-1:0] lo_thresh,
    output logic [OFF_W-1:0] hi_thresh,
    output logic             wr_hold,
    output logic             wr_take
);
    localparam logic [OFF_W-1:0] DEF_V = OFF_W'(OFF_DEF);

    win_phase_t phase_q;
    logic       win_open;
    logic       load_now;

    // Decode whether the window is still open
    always_comb win_open = (phase_q != WIN_SHUT);

    // Accept a load and gate the write strobe
    always_comb begin
        load_now = !prog_n && in_ready && win_open;
        wr_hold  = load_now;
        wr_take  = wen_a && wen_b && in_ready && !load_now;
    end

    // Window phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= WIN_OPEN;
        else if (wr_take)    phase_q <= WIN_SHUT;
        else if (load_now)   phase_q <= WIN_LOADED;
        else if (win_open)   phase_q <= WIN_OPEN;
    end

    // Threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_thresh <= DEF_V;
            hi_thresh <= DEF_V;
        end else if (load_now) begin
            hi_thresh <= prog_val;
            if (phase_q != WIN_LOADED) lo_thresh <= prog_val;
        end
    end

    // R5
    lo_keep_on_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && phase_q == WIN_LOADED) |=> $stable(lo_thresh));

    // R8
    window_stays_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == WIN_SHUT) |=> (phase_q == WIN_SHUT));

    // R8
    shut_freezes_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == WIN_SHUT) |=> ($stable(lo_thresh) && $stable(hi_thresh)));

    // R6
    no_load_without_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready) |=> ($stable(lo_thresh) && $stable(hi_thresh)));

endmodule

// File: rtl/lvl_flag_eval.sv
// Module: registered half-full and near-boundary flag evaluation.
// Compares the incoming word count against the depth midpoint and against
// both thresholds, and registers the results.
// Assumes: fill_count is already in the clk domain and never exceeds DEPTH.
module lvl_flag_eval #(
    parameter int DEPTH = 2048,
    parameter int OFF_W = 10,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_count,
    input  logic [OFF_W-1:0] lo_thresh,
    input  logic [OFF_W-1:0] hi_thresh,
    output logic             half_full,
    output logic             near_edge
);
    localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

    logic [CNT_W-1:0] hi_mark;
    logic             low_zone;
    logic             high_zone;

    // Threshold comparisons on the raw count
    always_comb begin
        hi_mark   = DEPTH_V - CNT_W'(hi_thresh);
        low_zone  = fill_count <= CNT_W'(lo_thresh);
        high_zone = fill_count >= hi_mark;
    end

    // Register both flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_full <= 1'b0;
            near_edge <= 1'b1;
        end else begin
            half_full <= (fill_count >= HALF_V);
            near_edge <= low_zone || high_zone;
        end
    end

    // R2
    half_full_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count >= HALF_V) |=> half_full);

    // R3
    near_empty_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count <= CNT_W'(lo_thresh)) |=> near_edge);

endmodule

// File: rtl/fifo_level_flags.sv
// Module: top of the FIFO level-flag block.
// Joins the threshold loader and the flag evaluator for a DEPTH-word FIFO.
// Assumes: single write-clock domain; count supplied by upstream pointer logic.
module fifo_level_flags #(
    parameter int DEPTH   = 2048,
    parameter int OFF_W   = 10,
    parameter int OFF_DEF = 256,
    parameter int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic [OFF_W-1:0] prog_val,
    input  logic             wen_a,
    input  logic             wen_b,
    input  logic             in_ready,
    input  logic [CNT_W-1:0] fill_count,
    output logic             wr_take,
    output logic             wr_hold,
    output logic [OFF_W-1:0] lo_thresh,
    output logic [OFF_W-1:0] hi_thresh,
    output logic             half_full,
    output logic             near_edge
);
    lvl_offset_prog #(
        .OFF_W   (OFF_W),
        .OFF_DEF (OFF_DEF)
    ) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_n    (prog_n),
        .prog_val  (prog_val),
        .wen_a     (wen_a),
        .wen_b     (wen_b),
        .in_ready  (in_ready),
        .lo_thresh (lo_thresh),
        .hi_thresh (hi_thresh),
        .wr_hold   (wr_hold),
        .wr_take   (wr_take)
    );

    lvl_flag_eval #(
        .DEPTH (DEPTH),
        .OFF_W (OFF_W),
        .CNT_W (CNT_W)
    ) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_count (fill_count),
        .lo_thresh  (lo_thresh),
        .hi_thresh  (hi_thresh),
        .half_full  (half_full),
        .near_edge  (near_edge)
    );

    // R7
    hold_excludes_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |-> !wr_take);

    // R9
    take_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (in_ready && wen_a && wen_b));

endmodule

// File: tb/test_fifo_level_flags.sv
module test_fifo_level_flags;
    localparam int DEPTH = 2048;
    localparam int CW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_n = 1'b1;
    logic [9:0]    prog_val = '0;
    logic          wen_a = 1'b0, wen_b = 1'b0, in_ready = 1'b1;
    logic [CW-1:0] fill_count = '0;
    logic          wr_take, wr_hold, half_full, near_edge;
    logic [9:0]    lo_thresh, hi_thresh;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    // reference model state
    int  m_lo = 256, m_hi = 256;
    bit  m_win = 1, m_prev = 0, m_hf = 0, m_ne = 1;

    fifo_level_flags i_fifo_level_flags (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .prog_val(prog_val),
        .wen_a(wen_a), .wen_b(wen_b), .in_ready(in_ready),
        .fill_count(fill_count), .wr_take(wr_take), .wr_hold(wr_hold),
        .lo_thresh(lo_thresh), .hi_thresh(hi_thresh),
        .half_full(half_full), .near_edge(near_edge));

    always #5 clk = ~clk;

    // Behavioural model update on each rising edge
    always @(posedge clk) begin
        bit ld, fire;
        int c;
        if (!rst_n) begin
            m_lo = 256; m_hi = 256; m_win = 1; m_prev = 0; m_hf = 0; m_ne = 1;
        end else begin
            c    = int'(fill_count);
            ld   = !prog_n && in_ready && m_win;
            fire = wen_a && wen_b && in_ready && !ld;
            m_hf = (c >= DEPTH / 2);
            m_ne = (c <= m_lo) || (c >= DEPTH - m_hi);
            if (ld) begin
                if (!m_prev) m_lo = int'(prog_val);
                m_hi = int'(prog_val);
            end
            m_prev = ld;
            if (fire) m_win = 0;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from the edge
    task automatic check_all();
        bit ld;
        ld = !prog_n && in_ready && m_win;
        cmp("R2 half_full", int'(half_full), int'(m_hf));
        cmp("R3 near_edge", int'(near_edge), int'(m_ne));
        cmp("R4 lo_thresh", int'(lo_thresh), m_lo);
        cmp("R5 hi_thresh", int'(hi_thresh), m_hi);
        cmp("R7 wr_hold",   int'(wr_hold),   int'(ld));
        cmp("R9 wr_take",   int'(wr_take),   int'(wen_a && wen_b && in_ready && !ld));
    endtask

    task automatic step(input bit pn, input int pv, input bit wa, input bit wb,
                        input bit ir, input int cnt);
        @(negedge clk);
        check_all();
        prog_n = pn; prog_val = 10'(pv); wen_a = wa; wen_b = wb;
        in_ready = ir; fill_count = CW'(cnt);
    endtask

    task automatic idle(input int cnt);
        step(1, 0, 0, 0, 1, cnt);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        prog_n = 1; wen_a = 0; wen_b = 0; fill_count = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cmp("R1 lo_thresh", int'(lo_thresh), 256);
        cmp("R1 hi_thresh", int'(hi_thresh), 256);
        cmp("R1 half_full", int'(half_full), 0);
        cmp("R1 near_edge", int'(near_edge), 1);
    endtask

    initial begin
        int sweep[8] = '{0, 256, 257, 1023, 1024, 1791, 1792, 2048};
        do_reset();
        // R2/R3 default thresholds
        foreach (sweep[i]) idle(sweep[i]);
        idle(500);
        // R6: strobe without in_ready ignored
        step(0, 1000, 0, 0, 0, 500);
        idle(500);
        @(negedge clk);
        cmp("R6 lo unchanged", int'(lo_thresh), 256);
        cmp("R6 hi unchanged", int'(hi_thresh), 256);
        // R4 then R5; write enables high to exercise R7
        step(0, 100, 1, 1, 1, 0);
        step(0, 900, 1, 1, 1, 0);
        step(1, 0, 0, 0, 1, 0);
        @(negedge clk);
        cmp("R4 lo loaded", int'(lo_thresh), 100);
        cmp("R5 hi reloaded", int'(hi_thresh), 900);
        // fresh pair after a gap, then repeated load
        step(0, 50, 0, 0, 1, 0);
        step(0, 300, 0, 0, 1, 0);
        step(1, 0, 0, 0, 1, 0);
        foreach (sweep[i]) idle(sweep[i]);
        idle(1747); idle(1748); idle(50); idle(51);
        // R8: first write closes the window
        step(1, 0, 1, 1, 1, 10);
        step(0, 5, 1, 1, 1, 11);
        step(1, 0, 0, 0, 1, 12);
        @(negedge clk);
        cmp("R8 lo frozen", int'(lo_thresh), 50);
        cmp("R8 hi frozen", int'(hi_thresh), 300);
        // R1 again after second reset
        do_reset();
        for (int k = 0; k < 400; k++)
            step(($urandom % 4) != 0, int'($urandom % 1024), $urandom % 2,
                 $urandom % 2, ($urandom % 5) != 0, int'($urandom % 2049));
        idle(0);
        @(negedge clk); check_all();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule